// File: doc/BRIEF.md
# Timed Output Event Staging Bank

This block holds one timed output event while software assembles it over a word-wide register bus. Software picks a destination channel, writes a wide timestamp as two words, writes an event address and as many 32-bit slices of a wide payload as it needs, then writes the commit register. That write hands the assembled event to a downstream queue as a single-cycle valid pulse, together with the registered channel, timestamp, address and payload.

A write to either timestamp word zeroes the staged address and the whole payload in the same clock edge. Payloads shorter than the full width are therefore zero-padded without any extra software work. Because only the timestamp clears the payload, software can change just the channel and commit again. The same event is then sent to several channels in turn.

A 5-bit status word records why the most recent commit was refused: the queue was full, or the event was late (underflow). Either condition drops the event. The word keeps its value until the next commit.

Top module: `event_stage`

## Requirements
- R1: A bus write to timestamp offset 1 (low word) or offset 2 (high word) loads zero into the staged address and into every payload word, in the same clock edge that stores the timestamp word. A readback in the following cycle returns zero.
- R2: Address (offset 3) and payload writes made after the timestamp write keep their value through any number of commits. They change only on another write to the same register or on a timestamp write.
- R3: The payload is DATA_W/32 words, read and written at offsets 8 to 8+N-1. Offset 8+k holds element N-1-k, and element i is payload bits [32i+31:32i]. The least significant word therefore sits at offset 8+N-1.
- R4: A write to offset 4 (any data) with the queue not full and no underflow drives evValid high for exactly the one cycle after that edge. During that cycle evChannel, evTimestamp, evAddress and evData equal the staged values.
- R5: Payload words not written since the last timestamp write read back as zero and are sent as zero.
- R6: If queueFull is high during the commit write, status bit 0 (value 1) is set and no evValid pulse occurs. If qUnderflow is high, status bit 1 (value 2) is set and no pulse occurs. Both can be set together (value 3).
- R7: The status word (statusOut, and offset 5 on the read port) changes only on a commit write. A clean commit clears it to 0. Bits 4:2 always read 0.
- R8: Writing only the channel (offset 0) and committing again re-issues the same timestamp, address and payload with the new channel.
- R9: After reset, every staged register, the status word, evValid and all event outputs are zero.
- R10: The timestamp is TS_W=63 bits. The low word gives bits 31:0. The high word's data bits 30:0 give bits 62:32, and its bit 31 is ignored and reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Bus write strobe |
| busAddr | input | BUS_ADDR_W | Bus write word offset |
| busWdata | input | 32 | Bus write data |
| rdAddr | input | BUS_ADDR_W | Read port word offset |
| rdData | output | 32 | Read data for rdAddr (combinational) |
| statusOut | output | 5 | Status word of the last commit |
| queueFull | input | 1 | Downstream queue cannot accept an event |
| qUnderflow | input | 1 | Downstream reports the staged timestamp is already late |
| evValid | output | 1 | One-cycle event hand-off pulse |
| evChannel | output | CHAN_W | Channel of the handed-off event |
| evTimestamp | output | TS_W | Timestamp of the handed-off event |
| evAddress | output | ADDR_W | Address of the handed-off event |
| evData | output | DATA_W | Payload of the handed-off event |

## Verification
On every cycle the assertions check several properties of the staged state and the event outputs. A timestamp write leaves address and payload zero. Staged address and payload hold still when nothing writes them. evValid only follows an accepted commit and carries the staged payload. A full-queue commit yields status bit 0 with no pulse. The status word never moves without a commit.

Only the bench scenarios can show the following behaviour:
- the word-order mapping of payload elements to offsets;
- zero padding over every payload length from empty to full;
- ganged re-commits to new channels;
- the masking of the high timestamp bit.

// File: rtl/event_stage_pkg.sv
package event_stage_pkg;
  localparam int OFS_CHAN   = 0;
  localparam int OFS_TS_LO  = 1;
  localparam int OFS_TS_HI  = 2;
  localparam int OFS_ADDR   = 3;
  localparam int OFS_COMMIT = 4;
  localparam int OFS_STATUS = 5;
  localparam int DATA_BASE  = 8;
  localparam int STATUS_W   = 5;

  typedef struct packed {
    logic selWr;
    logic tsLoWr;
    logic tsHiWr;
    logic addrWr;
    logic dataWr;
    logic commit;
  } stage_strobe_t;
endpackage

// File: rtl/event_stage_ctrl.sv
module event_stage_ctrl
  import event_stage_pkg::*;
#(
  parameter int BUS_ADDR_W = 5,
  parameter int N_WORDS    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [BUS_ADDR_W-1:0] busAddr,
  input  logic                  queueFull,
  input  logic                  qUnderflow,
  output stage_strobe_t         strobe,
  output logic [STATUS_W-1:0]   statusOut,
  output logic                  evValid
);
  localparam int DATA_END = DATA_BASE + N_WORDS;

  logic inDataRange;

  always_comb begin
    inDataRange   = (int'(busAddr) >= DATA_BASE) && (int'(busAddr) < DATA_END);
    strobe.selWr  = busWe && (busAddr == BUS_ADDR_W'(OFS_CHAN));
    strobe.tsLoWr = busWe && (busAddr == BUS_ADDR_W'(OFS_TS_LO));
    strobe.tsHiWr = busWe && (busAddr == BUS_ADDR_W'(OFS_TS_HI));
    strobe.addrWr = busWe && (busAddr == BUS_ADDR_W'(OFS_ADDR));
    strobe.dataWr = busWe && inDataRange;
    strobe.commit = busWe && (busAddr == BUS_ADDR_W'(OFS_COMMIT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusOut <= '0;
      evValid   <= 1'b0;
    end else begin
      evValid <= strobe.commit && !queueFull && !qUnderflow;
      if (strobe.commit) begin
        statusOut <= {{(STATUS_W-2){1'b0}}, qUnderflow, queueFull};
      end
    end
  end
endmodule

// File: rtl/event_stage_dp.sv
module event_stage_dp
  import event_stage_pkg::*;
#(
  parameter int BUS_ADDR_W = 5,
  parameter int CHAN_W     = 8,
  parameter int TS_W       = 63,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  stage_strobe_t         strobe,
  input  logic [BUS_ADDR_W-1:0] busAddr,
  input  logic [31:0]           busWdata,
  output logic [CHAN_W-1:0]     stagedChan,
  output logic [TS_W-1:0]       stagedTs,
  output logic [ADDR_W-1:0]     stagedAddr,
  output logic [DATA_W-1:0]     stagedData,
  output logic [CHAN_W-1:0]     evChannel,
  output logic [TS_W-1:0]       evTimestamp,
  output logic [ADDR_W-1:0]     evAddress,
  output logic [DATA_W-1:0]     evData
);
  localparam int N_WORDS = DATA_W / 32;
  localparam int TS_HI_W = TS_W - 32;

  logic tsWrite;
  assign tsWrite = strobe.tsLoWr || strobe.tsHiWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedChan <= '0;
      stagedTs   <= '0;
    end else begin
      if (strobe.selWr)  stagedChan         <= busWdata[CHAN_W-1:0];
      if (strobe.tsLoWr) stagedTs[31:0]     <= busWdata;
      if (strobe.tsHiWr) stagedTs[TS_W-1:32] <= busWdata[TS_HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedAddr <= '0;
    end else if (tsWrite) begin
      stagedAddr <= '0;
    end else if (strobe.addrWr) begin
      stagedAddr <= busWdata[ADDR_W-1:0];
    end
  end

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    localparam int ELEM = N_WORDS - 1 - k;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stagedData[32*ELEM +: 32] <= '0;
      end else if (tsWrite) begin
        stagedData[32*ELEM +: 32] <= '0;
      end else if (strobe.dataWr && (busAddr == BUS_ADDR_W'(DATA_BASE + k))) begin
        stagedData[32*ELEM +: 32] <= busWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evChannel   <= '0;
      evTimestamp <= '0;
      evAddress   <= '0;
      evData      <= '0;
    end else if (strobe.commit) begin
      evChannel   <= stagedChan;
      evTimestamp <= stagedTs;
      evAddress   <= stagedAddr;
      evData      <= stagedData;
    end
  end
endmodule

// File: rtl/event_stage.sv
module event_stage
  import event_stage_pkg::*;
#(
  parameter int BUS_ADDR_W = 5,
  parameter int CHAN_W     = 8,
  parameter int TS_W       = 63,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [BUS_ADDR_W-1:0] busAddr,
  input  logic [31:0]           busWdata,
  input  logic [BUS_ADDR_W-1:0] rdAddr,
  output logic [31:0]           rdData,
  output logic [STATUS_W-1:0]   statusOut,
  input  logic                  queueFull,
  input  logic                  qUnderflow,
  output logic                  evValid,
  output logic [CHAN_W-1:0]     evChannel,
  output logic [TS_W-1:0]       evTimestamp,
  output logic [ADDR_W-1:0]     evAddress,
  output logic [DATA_W-1:0]     evData
);
  localparam int N_WORDS = DATA_W / 32;

  stage_strobe_t      strobe;
  logic [CHAN_W-1:0]  stagedChan;
  logic [TS_W-1:0]    stagedTs;
  logic [ADDR_W-1:0]  stagedAddr;
  logic [DATA_W-1:0]  stagedData;

  event_stage_ctrl #(
    .BUS_ADDR_W(BUS_ADDR_W),
    .N_WORDS   (N_WORDS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .queueFull (queueFull),
    .qUnderflow(qUnderflow),
    .strobe    (strobe),
    .statusOut (statusOut),
    .evValid   (evValid)
  );

  event_stage_dp #(
    .BUS_ADDR_W(BUS_ADDR_W),
    .CHAN_W    (CHAN_W),
    .TS_W      (TS_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .stagedChan (stagedChan),
    .stagedTs   (stagedTs),
    .stagedAddr (stagedAddr),
    .stagedData (stagedData),
    .evChannel  (evChannel),
    .evTimestamp(evTimestamp),
    .evAddress  (evAddress),
    .evData     (evData)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr == BUS_ADDR_W'(OFS_CHAN))   rdData = 32'(stagedChan);
    if (rdAddr == BUS_ADDR_W'(OFS_TS_LO))  rdData = stagedTs[31:0];
    if (rdAddr == BUS_ADDR_W'(OFS_TS_HI))  rdData = 32'(stagedTs[TS_W-1:32]);
    if (rdAddr == BUS_ADDR_W'(OFS_ADDR))   rdData = 32'(stagedAddr);
    if (rdAddr == BUS_ADDR_W'(OFS_STATUS)) rdData = 32'(statusOut);
    for (int k = 0; k < N_WORDS; k++) begin
      if (rdAddr == BUS_ADDR_W'(DATA_BASE + k)) rdData = stagedData[32*(N_WORDS-1-k) +: 32];
    end
  end
endmodule

// File: rtl/event_stage_chk.sv
module event_stage_chk
  import event_stage_pkg::*;
#(
  parameter int BUS_ADDR_W = 5,
  parameter int CHAN_W     = 8,
  parameter int TS_W       = 63,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 128
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWe,
  input logic [BUS_ADDR_W-1:0] busAddr,
  input logic                  queueFull,
  input logic                  qUnderflow,
  input logic                  evValid,
  input logic [STATUS_W-1:0]   statusOut,
  input logic [CHAN_W-1:0]     stagedChan,
  input logic [TS_W-1:0]       stagedTs,
  input logic [ADDR_W-1:0]     stagedAddr,
  input logic [DATA_W-1:0]     stagedData,
  input logic [CHAN_W-1:0]     evChannel,
  input logic [TS_W-1:0]       evTimestamp,
  input logic [DATA_W-1:0]     evData
);
  logic tsWr, addrWr, commitWr, commitOk, dataWr;
  assign tsWr     = busWe && ((busAddr == BUS_ADDR_W'(OFS_TS_LO)) || (busAddr == BUS_ADDR_W'(OFS_TS_HI)));
  assign addrWr   = busWe && (busAddr == BUS_ADDR_W'(OFS_ADDR));
  assign commitWr = busWe && (busAddr == BUS_ADDR_W'(OFS_COMMIT));
  assign commitOk = commitWr && !queueFull && !qUnderflow;
  assign dataWr   = busWe && (int'(busAddr) >= DATA_BASE);

  AST_TS_CLEARS_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    tsWr |=> (stagedData == '0) && (stagedAddr == '0)); // R1
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!tsWr && !addrWr) |=> $stable(stagedAddr)); // R2
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!tsWr && !dataWr) |=> $stable(stagedData)); // R2
  AST_VALID_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> $past(commitOk)); // R4
  AST_COMMIT_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    commitOk |=> evValid && (evData == $past(stagedData)) && (evTimestamp == $past(stagedTs))
                 && (evChannel == $past(stagedChan))); // R4
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (commitWr && queueFull) |=> (!evValid && statusOut[0])); // R6
  AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !commitWr |=> $stable(statusOut)); // R7
endmodule

bind event_stage event_stage_chk #(
  .BUS_ADDR_W(BUS_ADDR_W),
  .CHAN_W    (CHAN_W),
  .TS_W      (TS_W),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWe      (busWe),
  .busAddr    (busAddr),
  .queueFull  (queueFull),
  .qUnderflow (qUnderflow),
  .evValid    (evValid),
  .statusOut  (statusOut),
  .stagedChan (stagedChan),
  .stagedTs   (stagedTs),
  .stagedAddr (stagedAddr),
  .stagedData (stagedData),
  .evChannel  (evChannel),
  .evTimestamp(evTimestamp),
  .evData     (evData)
);

// File: tb/sim_event_stage.sv
`timescale 1ns/1ps
module sim_event_stage;
  localparam int BAW = 5;
  localparam int NW  = 4;
  localparam int DW  = NW * 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           busWe = 1'b0;
  logic [BAW-1:0] busAddr = '0;
  logic [31:0]    busWdata = '0;
  logic [BAW-1:0] rdAddr = '0;
  logic [31:0]    rdData;
  logic [4:0]     statusOut;
  logic           queueFull = 1'b0;
  logic           qUnderflow = 1'b0;
  logic           evValid;
  logic [7:0]     evChannel;
  logic [62:0]    evTimestamp;
  logic [15:0]    evAddress;
  logic [DW-1:0]  evData;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  event_stage u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .rdAddr(rdAddr), .rdData(rdData), .statusOut(statusOut), .queueFull(queueFull),
    .qUnderflow(qUnderflow), .evValid(evValid), .evChannel(evChannel),
    .evTimestamp(evTimestamp), .evAddress(evAddress), .evData(evData)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = BAW'(a); busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    rdAddr = BAW'(a);
    #1 v = rdData;
  endtask

  function automatic logic [31:0] pat(input int len, input int i);
    return 32'hA500_0000 + 32'(len * 256 + i * 17 + 3);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nRun++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0]   v;
    logic [DW-1:0] expData;
    logic [62:0]   expTs;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 evValid", DW'(evValid), '0);
    check("R9 status", DW'(statusOut), '0);
    check("R9 evData", evData, '0);
    for (int a = 0; a < 12; a++) begin
      rd(a, v);
      check("R9 readback", DW'(v), '0);
    end
    rstN = 1'b1;
    @(negedge clk);

    for (int len = 0; len <= NW; len++) begin
      // dirty every register so the R1 clear is visible
      wr(3, 32'hFFFF);
      for (int k = 0; k < NW; k++) wr(8 + k, 32'hDEAD_BEEF);
      expTs = {31'(len * 3 + 1), 32'h1000_0000 + 32'(len)};
      wr(1, expTs[31:0]);
      rd(3, v); check("R1 addr cleared by ts low", DW'(v), '0);
      for (int k = 0; k < NW; k++) begin
        rd(8 + k, v); check("R1 data cleared by ts low", DW'(v), '0);
      end
      wr(3, 32'hBBBB);
      wr(8, 32'h1111_2222);
      wr(2, {1'b0, expTs[62:32]});
      rd(3, v); check("R1 addr cleared by ts high", DW'(v), '0);
      rd(8, v); check("R1 data cleared by ts high", DW'(v), '0);
      wr(0, 32'(len + 1));
      wr(3, 32'(16'h0C00 + len));
      expData = '0;
      for (int i = 0; i < len; i++) begin
        wr(8 + NW - 1 - i, pat(len, i));
        expData[32*i +: 32] = pat(len, i);
      end
      for (int k = 0; k < NW; k++) begin
        rd(8 + k, v);
        check("R3 R5 word readback", DW'(v), DW'(expData[32*(NW-1-k) +: 32]));
      end
      wr(4, 32'h0);
      check("R4 evValid", DW'(evValid), DW'(1));
      check("R4 R5 evData", evData, expData);
      check("R4 evTimestamp", DW'(evTimestamp), DW'(expTs));
      check("R4 evAddress", DW'(evAddress), DW'(16'h0C00 + len));
      check("R4 evChannel", DW'(evChannel), DW'(len + 1));
      @(negedge clk);
      check("R4 single pulse", DW'(evValid), '0);
      // R8 ganged re-commit on two further channels
      for (int c = 0; c < 2; c++) begin
        wr(0, 32'(40 + c));
        wr(4, 32'h0);
        check("R8 evValid", DW'(evValid), DW'(1));
        check("R8 evChannel", DW'(evChannel), DW'(40 + c));
        check("R8 evData", evData, expData);
        check("R8 evTimestamp", DW'(evTimestamp), DW'(expTs));
        check("R2 R8 evAddress", DW'(evAddress), DW'(16'h0C00 + len));
      end
    end

    // R6 / R7 status sweep over all full/underflow combinations
    for (int s = 0; s < 4; s++) begin
      queueFull = s[0]; qUnderflow = s[1];
      wr(4, 32'h0);
      queueFull = 1'b0; qUnderflow = 1'b0;
      check("R6 evValid", DW'(evValid), DW'(s == 0));
      check("R6 R7 statusOut", DW'(statusOut), DW'(s));
      rd(5, v); check("R7 status read", DW'(v), DW'(s));
      // R7 hold across non-commit writes
      wr(1, 32'h5);
      wr(8, 32'h7);
      wr(0, 32'h3);
      check("R7 status held", DW'(statusOut), DW'(s));
    end
    wr(4, 32'h0);
    check("R7 clean commit clears", DW'(statusOut), '0);

    // R10 high timestamp bit 31 ignored
    wr(1, 32'hCAFE_F00D);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); check("R10 ts high readback", DW'(v), DW'(32'h7FFF_FFFF));
    rd(1, v); check("R10 ts low readback", DW'(v), DW'(32'hCAFE_F00D));
    wr(4, 32'h0);
    check("R10 evTimestamp", DW'(evTimestamp), DW'({31'h7FFF_FFFF, 32'hCAFE_F00D}));
    check("R5 empty payload sent as zero", evData, '0);

    finish_run();
  end
endmodule